// File: doc/BRIEF.md
# Attribute Register Port with Index/Data Toggle

This block is the register port of a video attribute controller. A host processor reaches all of its registers through a single shared byte-wide write address. An internal toggle decides what each write at that address means. In the index phase the byte selects a register. In the data phase the byte is stored into the selected register. After a data write the toggle returns to the index phase. Software can always put the toggle into a known state by reading the input-status address, because that read forces the index phase.

The index byte also carries a display-enable bit, so loading an index can blank or unblank the video output. The block holds sixteen palette entries, a mode-control register, an overscan colour register, two more auxiliary registers and a colour-select register. From these it drives a display-enable flag, a blink-enable flag and a four-bit page-select value for the colour lookup stage that follows it.

A second address returns the contents of the currently indexed register, and reading it does not move the toggle. Read data is registered and is valid in the cycle after the read strobe.

Top module: `attr_port`

## Requirements
- R1: After a synchronous reset, the toggle is in the index phase, `disp_en`, `blink_en` and `page_sel` are 0, and every register reads back 0x00.
- R2: When the toggle is in the index phase, a write to the shared address (0x3C0) loads the index byte. The next write to that address stores its byte into the register whose number is in index bits 4:0, and the toggle then returns to the index phase.
- R3: A read of the status address (0x3DA) forces the index phase, so the next write to the shared address is taken as an index and does not change any register.
- R4: `disp_en` equals bit 5 of the most recently written index byte. An index written with bit 5 clear blanks the display until an index with bit 5 set is written.
- R5: A read of the data address (0x3C1) returns the register selected by the current index and leaves the toggle unchanged.
- R6: A read of the shared address returns the stored index byte unchanged, including bit 5.
- R7: Register numbers 0x15 to 0x1F are not implemented. A data write to one of them consumes the data phase but changes no register, and a read of one returns 0x00.
- R8: `blink_en` equals bit 3 of the mode-control register (number 0x10).
- R9: When bit 7 of mode-control is 1, `page_sel` equals bits 3:0 of the colour-select register (number 0x14). When bit 7 is 0, `page_sel` equals {2'b00, colour-select bits 3:2}.
- R10: Read data appears one cycle after the read strobe and holds until the next read. Reads of the status address or of any other unmapped address return 0x00.
- R11: Each implemented register, including palette entries 0x00 and 0x0F and overscan 0x11, stores its value independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Port address of the current access |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| disp_en | output | 1 | Video output enable taken from the index byte |
| blink_en | output | 1 | Blink enable from mode-control |
| page_sel | output | 4 | Colour page select |

## Verification
The toggle is driven with four patterns. Plain index/data pairs show that the phase alternates. A status read in the middle of a pair shows the forced return to the index phase. Repeated data-port reads between an index write and its data write show that reads do not advance the toggle. Data writes to unimplemented numbers show that the data phase is consumed without any register changing. Mode-control is written with bit 7 both set and clear under the same colour-select value, which separates the two page encodings. Boundary numbers 0x00, 0x0F, 0x11, 0x14 and 0x1F, a readback of registers written earlier, and a reset in the middle of a run show that registers do not alias each other and that reset clears them.

// File: rtl/attr_port_pkg.sv
// Package: shared constants and types for the attribute register port.
// Assumes byte-wide data and a five-bit register number inside the index byte.
package attr_port_pkg;

    // Phase of the shared write address
    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    // Register numbers whose values drive outputs
    localparam logic [4:0] REG_MODE     = 5'h10;
    localparam logic [4:0] REG_OVERSCAN = 5'h11;
    localparam logic [4:0] REG_CSEL     = 5'h14;

    // Bit positions inside the index byte and the mode-control register
    localparam int DE_BIT     = 5;
    localparam int BLINK_BIT  = 3;
    localparam int PAGING_BIT = 7;

endpackage

// File: rtl/attr_toggle.sv
// Module: index/data toggle and index register.
// Decodes writes at the shared address, keeps the phase and the last index
// byte, and produces a register write strobe during the data phase.
// Assumes that the bus never raises rd_en and wr_en in the same cycle.
module attr_toggle
    import attr_port_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 8,
    parameter int          IDX_W       = 5,
    parameter logic [15:0] SHARED_ADDR = 16'h03C0,
    parameter logic [15:0] STATUS_ADDR = 16'h03DA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output phase_e            phase_o,
    output logic [DATA_W-1:0] index_byte_o,
    output logic [IDX_W-1:0]  reg_num_o,
    output logic              reg_we_o
);

    localparam logic [ADDR_W-1:0] SHARED_A = ADDR_W'(SHARED_ADDR);
    localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_ADDR);

    phase_e            phase_q;
    logic [DATA_W-1:0] index_q;
    logic              shared_wr;
    logic              status_rd;

    // Decode the two accesses that move the toggle
    always_comb begin
        shared_wr = wr_en && (bus_addr == SHARED_A);
        status_rd = rd_en && (bus_addr == STATUS_A);
    end

    // Phase register: a status read forces index, a shared write flips it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_INDEX;
        end else if (status_rd) begin
            phase_q <= PH_INDEX;
        end else if (shared_wr) begin
            phase_q <= (phase_q == PH_INDEX) ? PH_DATA : PH_INDEX;
        end
    end

    // Index register: captures the whole index byte in the index phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
        end else if (shared_wr && (phase_q == PH_INDEX)) begin
            index_q <= wr_data;
        end
    end

    // Outputs toward the register file and the read path
    always_comb begin
        phase_o      = phase_q;
        index_byte_o = index_q;
        reg_num_o    = index_q[IDX_W-1:0];
        reg_we_o     = shared_wr && (phase_q == PH_DATA);
    end

endmodule

// File: rtl/attr_regfile.sv
// Module: attribute register file.
// Holds NUM_REGS byte registers. A write lands only on an implemented
// register number; numbers at or above NUM_REGS are dropped.
module attr_regfile #(
    parameter int DATA_W   = 8,
    parameter int IDX_W    = 5,
    parameter int NUM_REGS = 21
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [IDX_W-1:0]                 num,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);

    generate
        for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
            logic [DATA_W-1:0] val_q;

            // One register: loads when the strobe selects its number
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else if (we && (num == IDX_W'(gi))) begin
                    val_q <= wdata;
                end
            end

            assign regs_o[gi] = val_q;
        end
    endgenerate

endmodule

// File: rtl/attr_readout.sv
// Module: read path and decoded outputs.
// Registers the read data for the shared and data addresses, returns zero
// elsewhere, and decodes blink and page select from the register file.
module attr_readout
    import attr_port_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 8,
    parameter int          IDX_W       = 5,
    parameter int          NUM_REGS    = 21,
    parameter int          PAGE_W      = 4,
    parameter logic [15:0] SHARED_ADDR = 16'h03C0,
    parameter logic [15:0] RDATA_ADDR  = 16'h03C1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic                            rd_en,
    input  logic [DATA_W-1:0]               index_byte,
    input  logic [IDX_W-1:0]                reg_num,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    output logic [DATA_W-1:0]               rd_data,
    output logic                            blink_en,
    output logic [PAGE_W-1:0]               page_sel
);

    localparam logic [ADDR_W-1:0] SHARED_A = ADDR_W'(SHARED_ADDR);
    localparam logic [ADDR_W-1:0] RDATA_A  = ADDR_W'(RDATA_ADDR);
    localparam int                HALF_W   = PAGE_W / 2;

    logic [DATA_W-1:0] sel_reg;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] mode_r;
    logic [DATA_W-1:0] csel_r;

    // Selected register, zero for unimplemented numbers
    always_comb begin
        sel_reg = '0;
        if (int'(reg_num) < NUM_REGS) begin
            sel_reg = regs[reg_num];
        end
    end

    // Address decode of the read byte
    always_comb begin
        if (bus_addr == SHARED_A) begin
            rd_next = index_byte;
        end else if (bus_addr == RDATA_A) begin
            rd_next = sel_reg;
        end else begin
            rd_next = '0;
        end
    end

    // Read data register: updates on a read strobe, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_next;
        end
    end

    // Decode of mode-control and colour-select into outputs
    always_comb begin
        mode_r   = regs[REG_MODE];
        csel_r   = regs[REG_CSEL];
        rd_data  = rd_q;
        blink_en = mode_r[BLINK_BIT];
        if (mode_r[PAGING_BIT]) begin
            page_sel = csel_r[PAGE_W-1:0];
        end else begin
            page_sel = {{(PAGE_W-HALF_W){1'b0}}, csel_r[PAGE_W-1:PAGE_W-HALF_W]};
        end
    end

endmodule

// File: rtl/attr_port.sv
// Module: attribute register port top.
// Joins the index/data toggle, the register file and the read path. The
// display-enable flag is taken from bit DE_BIT of the stored index byte.
// Assumes a byte bus with single-cycle strobes that are never both high.
module attr_port
    import attr_port_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 8,
    parameter int          IDX_W       = 5,
    parameter int          NUM_REGS    = 21,
    parameter int          PAGE_W      = 4,
    parameter logic [15:0] SHARED_ADDR = 16'h03C0,
    parameter logic [15:0] RDATA_ADDR  = 16'h03C1,
    parameter logic [15:0] STATUS_ADDR = 16'h03DA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              disp_en,
    output logic              blink_en,
    output logic [PAGE_W-1:0] page_sel
);

    phase_e                          ff_phase;
    logic [DATA_W-1:0]               index_byte;
    logic [IDX_W-1:0]                reg_num;
    logic                            reg_we;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    attr_toggle #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .IDX_W       (IDX_W),
        .SHARED_ADDR (SHARED_ADDR),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_toggle (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .phase_o      (ff_phase),
        .index_byte_o (index_byte),
        .reg_num_o    (reg_num),
        .reg_we_o     (reg_we)
    );

    attr_regfile #(
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .NUM_REGS (NUM_REGS)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .num    (reg_num),
        .wdata  (wr_data),
        .regs_o (regs)
    );

    attr_readout #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .IDX_W       (IDX_W),
        .NUM_REGS    (NUM_REGS),
        .PAGE_W      (PAGE_W),
        .SHARED_ADDR (SHARED_ADDR),
        .RDATA_ADDR  (RDATA_ADDR)
    ) u_read (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .rd_en      (rd_en),
        .index_byte (index_byte),
        .reg_num    (reg_num),
        .regs       (regs),
        .rd_data    (rd_data),
        .blink_en   (blink_en),
        .page_sel   (page_sel)
    );

    // Display enable taken straight from the stored index byte
    assign disp_en = index_byte[DE_BIT];

endmodule

// File: rtl/attr_port_chk.sv
// Module: assertion checker for attr_port, attached with bind below.
// Observes the top-level ports and the toggle phase.
module attr_port_chk #(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 8,
    parameter int          PAGE_W      = 4,
    parameter logic [15:0] SHARED_ADDR = 16'h03C0,
    parameter logic [15:0] RDATA_ADDR  = 16'h03C1,
    parameter logic [15:0] STATUS_ADDR = 16'h03DA
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              disp_en,
    input logic              blink_en,
    input logic [PAGE_W-1:0] page_sel,
    input logic              phase
);

    localparam logic [ADDR_W-1:0] SHARED_A = ADDR_W'(SHARED_ADDR);
    localparam logic [ADDR_W-1:0] RDATA_A  = ADDR_W'(RDATA_ADDR);
    localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_ADDR);

    // R1: a reset cycle leaves outputs cleared and the toggle at index
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!disp_en && !blink_en && (page_sel == '0) && !phase));

    // R2: every shared write without a status read flips the phase
    a_r2_phase_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (bus_addr == SHARED_A) && !rd_en) |=> (phase != $past(phase)));

    // R3: a status read returns the toggle to index
    a_r3_status_to_index: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (bus_addr == STATUS_A)) |=> !phase);

    // R4: an index write sets the display flag from its bit 5
    a_r4_disp_en_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (bus_addr == SHARED_A) && !phase) |=> (disp_en == $past(wr_data[5])));

    // R5: a data-port read leaves the phase alone
    a_r5_read_keeps_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (bus_addr == RDATA_A)) |=> $stable(phase));

    // R8: blink changes only after a data-phase write
    a_r8_blink_only_on_data: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (bus_addr == SHARED_A) && phase) |=> $stable(blink_en));

    // R10: read data holds when no read is strobed
    a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind attr_port attr_port_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PAGE_W      (PAGE_W),
    .SHARED_ADDR (SHARED_ADDR),
    .RDATA_ADDR  (RDATA_ADDR),
    .STATUS_ADDR (STATUS_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .disp_en  (disp_en),
    .blink_en (blink_en),
    .page_sel (page_sel),
    .phase    (ff_phase)
);

// File: tb/attr_port_tb.sv
`timescale 1ns/1ps
// Bench: scoreboard. Read tasks queue the expected byte; a monitor pops and
// compares each one when the registered read data is due.
module attr_port_tb;

    localparam logic [15:0] A_SHARED = 16'h03C0;
    localparam logic [15:0] A_RDATA  = 16'h03C1;
    localparam logic [15:0] A_STATUS = 16'h03DA;
    localparam logic [15:0] A_OTHER  = 16'h03C2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        disp_en;
    logic        blink_en;
    logic [3:0]  page_sel;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    attr_port u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .disp_en  (disp_en),
        .blink_en (blink_en),
        .page_sel (page_sel)
    );

    always #2 clk = ~clk;

    // Note which edges captured a read strobe
    always @(posedge clk) rd_seen <= rd_en;

    // Monitor: compare registered read data against the queue
    always @(negedge clk) begin
        if (rd_seen) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: read with nothing expected, got %02h", rd_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_fail++;
                    $display("FAIL %s: rd_data=%02h expected %02h", t, rd_data, e);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got 1 expected 0");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 disp_en", {7'd0, disp_en}, 8'h00);
        chk("R1 blink_en", {7'd0, blink_en}, 8'h00);
        chk("R1 page_sel", {4'd0, page_sel}, 8'h00);
        rst_n = 1'b1;
        bus_rd(A_SHARED, 8'h00, "R1 index after reset");
        bus_rd(A_RDATA, 8'h00, "R1 reg0 after reset");

        // R2: index then data, then back to index
        bus_wr(A_SHARED, 8'h05);
        bus_wr(A_SHARED, 8'h2A);
        bus_rd(A_RDATA, 8'h2A, "R2 reg5 stored");
        bus_rd(A_SHARED, 8'h05, "R6 index readback");
        chk("R4 disp_en off", {7'd0, disp_en}, 8'h00);
        bus_wr(A_SHARED, 8'h27);
        chk("R4 disp_en on", {7'd0, disp_en}, 8'h01);
        bus_wr(A_SHARED, 8'h3F);
        bus_rd(A_RDATA, 8'h3F, "R2 third write is index, reg7 stored");

        // R5: data reads do not advance the toggle
        bus_wr(A_SHARED, 8'h25);
        bus_rd(A_RDATA, 8'h2A, "R5 reg5 read 1");
        bus_rd(A_RDATA, 8'h2A, "R5 reg5 read 2");
        bus_wr(A_SHARED, 8'h5C);
        bus_wr(A_SHARED, 8'h25);
        bus_rd(A_RDATA, 8'h5C, "R5 data write still landed");
        bus_rd(A_STATUS, 8'h00, "R10 status reads zero");

        // R3: status read in mid pair
        bus_wr(A_SHARED, 8'h31);
        bus_rd(A_STATUS, 8'h00, "R10 status reads zero");
        bus_wr(A_SHARED, 8'h30);
        bus_rd(A_SHARED, 8'h30, "R3 write after status is index");
        bus_wr(A_SHARED, 8'h08);
        chk("R8 blink set", {7'd0, blink_en}, 8'h01);
        chk("R9 page zero", {4'd0, page_sel}, 8'h00);
        bus_wr(A_SHARED, 8'h31);
        bus_rd(A_RDATA, 8'h00, "R3 overscan untouched");
        bus_rd(A_STATUS, 8'h00, "R10 status reads zero");

        // R4/R8/R9: blanking, paging encodings
        bus_wr(A_SHARED, 8'h10);
        chk("R4 blank", {7'd0, disp_en}, 8'h00);
        bus_wr(A_SHARED, 8'h88);
        chk("R8 blink with paging", {7'd0, blink_en}, 8'h01);
        bus_wr(A_SHARED, 8'h34);
        chk("R4 unblank", {7'd0, disp_en}, 8'h01);
        bus_wr(A_SHARED, 8'h0E);
        chk("R9 page bit7 set", {4'd0, page_sel}, 8'h0E);
        bus_wr(A_SHARED, 8'h30);
        bus_wr(A_SHARED, 8'h08);
        chk("R9 page bit7 clear", {4'd0, page_sel}, 8'h03);
        bus_wr(A_SHARED, 8'h30);
        bus_wr(A_SHARED, 8'h00);
        chk("R8 blink clear", {7'd0, blink_en}, 8'h00);

        // R7: unimplemented numbers
        bus_wr(A_SHARED, 8'h3F);
        bus_wr(A_SHARED, 8'hAA);
        bus_rd(A_RDATA, 8'h00, "R7 reg 0x1F reads zero");
        bus_rd(A_SHARED, 8'h3F, "R6 index with bit5 readback");
        bus_wr(A_SHARED, 8'h35);
        bus_wr(A_SHARED, 8'h77);
        bus_rd(A_RDATA, 8'h00, "R7 reg 0x15 reads zero");
        bus_wr(A_SHARED, 8'h25);
        bus_rd(A_RDATA, 8'h5C, "R7 reg5 unchanged");
        bus_rd(A_STATUS, 8'h00, "R10 status reads zero");
        bus_wr(A_SHARED, 8'h34);
        bus_rd(A_RDATA, 8'h0E, "R7 colour select unchanged");
        bus_rd(A_STATUS, 8'h00, "R10 status reads zero");
        chk("R9 page kept", {4'd0, page_sel}, 8'h03);

        // R11: boundary registers are independent
        bus_wr(A_SHARED, 8'h2F);
        bus_wr(A_SHARED, 8'h15);
        bus_wr(A_SHARED, 8'h20);
        bus_wr(A_SHARED, 8'h01);
        bus_wr(A_SHARED, 8'h31);
        bus_wr(A_SHARED, 8'h09);
        bus_wr(A_SHARED, 8'h2F);
        bus_rd(A_RDATA, 8'h15, "R11 palette 0x0F");
        bus_rd(A_STATUS, 8'h00, "R10 status reads zero");
        bus_wr(A_SHARED, 8'h20);
        bus_rd(A_RDATA, 8'h01, "R11 palette 0x00");
        bus_rd(A_STATUS, 8'h00, "R10 status reads zero");
        bus_wr(A_SHARED, 8'h31);
        bus_rd(A_RDATA, 8'h09, "R11 overscan");
        bus_rd(A_OTHER, 8'h00, "R10 unmapped reads zero");
        bus_rd(A_STATUS, 8'h00, "R10 status reads zero");

        // R1: reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset disp_en", {7'd0, disp_en}, 8'h00);
        chk("R1 mid reset page_sel", {4'd0, page_sel}, 8'h00);
        rst_n = 1'b1;
        bus_rd(A_SHARED, 8'h00, "R1 index cleared");
        bus_wr(A_SHARED, 8'h25);
        bus_rd(A_RDATA, 8'h00, "R1 reg5 cleared");

        repeat (3) @(negedge clk);
        chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
        report();
    end

endmodule